// File: doc/BRIEF.md
# Transmit Channel Priority Scheduler

This block decides which transmit channel may drive a shared 128-bit packet stream next. Each channel raises a trigger while its descriptor queue is non-empty. The block keeps, for every channel, a priority value and three control bits: enable, pause and teardown. Among the triggered channels that may run, the block picks the most urgent priority level. Inside that level it rotates fairly between channels.

The chosen channel keeps the grant until the last beat of its packet is taken by the sink. While it holds the grant, the block passes the packet source's beats and handshake through to the output, and it reports the channel number alongside them. Pause and teardown act at the packet boundary. Disable acts at once, even in the middle of a packet. When a teardown finishes, the channel's done flag goes high and its enable bit is cleared. This stops the channel cleanly so that it can be reconfigured.

Top module: `txch_sched`

## Requirements
- R1: After reset no grant is active (`grantValid`=0), every channel is disabled, every teardown-done flag is 0 and every priority is 0.
- R2: A channel is eligible only when its trigger is high, it is enabled, it is not paused and no teardown is pending on it. An ineligible channel is never granted.
- R3: The priority field is 4 bits wide. Value 0 is level 0, the most urgent; values 1 and 2 are levels 1 and 2; values 3 to 15 all map to level 3. The lowest eligible level wins, and empty levels are skipped in the same arbitration.
- R4: Inside a level, the search starts at the channel after the one last served at that level and wraps around. After reset, the search at every level starts at channel 0.
- R5: When idle with an eligible channel, the grant appears after the next clock edge. It stays on the same channel until a beat with `outValid`, `outReady` and `outEop` all high is taken. It is released at that edge, so the next grant comes one edge later.
- R6: While a grant is active, `outData` follows `srcData`, `outValid`/`outEop` follow `srcValid`/`srcEop`, and `srcReady` follows `outReady`. Without a grant, `outValid`, `outEop` and `srcReady` are 0.
- R7: Pausing a granted channel lets its current packet finish. The channel is then skipped until the pause is cleared.
- R8: Disabling the granted channel drops `grantValid` and `outValid` right after the write edge, in the middle of a packet. The grant is released at the following edge.
- R9: Teardown on a channel that holds no grant completes at the next edge. On the granted channel it completes at the edge that takes the end-of-packet beat. Completion sets `tdDone`, clears the enable bit and clears the teardown request. A write that sets enable clears `tdDone`.
- R10: A configuration write updates the priority only if the channel was disabled before that write. The control bits are always updated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| chTrig | input | NUM_CH | Per-channel trigger, high while the queue holds a descriptor |
| cfgWe | input | 1 | Configuration write strobe |
| cfgCh | input | CH_W | Channel addressed by the write |
| cfgPrio | input | 4 | Priority value to store |
| cfgEn | input | 1 | Enable bit value |
| cfgPause | input | 1 | Pause bit value |
| cfgTeardown | input | 1 | Teardown request value |
| srcData | input | DATA_W | Beat data from the granted channel's source |
| srcValid | input | 1 | Source beat valid |
| srcEop | input | 1 | Source beat is the last of its packet |
| srcReady | output | 1 | Sink acceptance returned to the source |
| outData | output | DATA_W | Streaming output data |
| outValid | output | 1 | Streaming output valid |
| outEop | output | 1 | Streaming output end-of-packet |
| outReady | input | 1 | Sink ready |
| grantValid | output | 1 | A channel currently holds the grant |
| grantCh | output | CH_W | Granted channel number |
| chEnable | output | NUM_CH | Current enable bit of each channel |
| tdDone | output | NUM_CH | Per-channel teardown-done flag |

## Verification
Teardown completion and the end-of-packet release can fall on the same clock edge. The bench provokes this by writing a teardown to the granted channel in the middle of its packet, then handing over the end-of-packet beat. It requires that the flag stays low through the remaining beats. It then requires that, right after the end-of-packet edge, the done flag is set, the enable bit is clear and the grant is free. A pause written during a packet collides with the packet boundary in the same way. The bench judges it by the order of the channels that a scoreboard of expected grants pops at each end-of-packet.

// File: rtl/txch_sched_pkg.sv
package txch_sched_pkg;

  // control -> datapath: whether the streaming path may pass beats
  typedef struct packed {
    logic pass;
  } gateStrbT;

  // datapath -> control: packet boundary taken by the sink
  typedef struct packed {
    logic eopAcc;
  } pktStrbT;

endpackage

// File: rtl/txch_prio_pick.sv
module txch_prio_pick #(
  parameter int NUM_CH = 4,
  parameter int LEVELS = 4,
  parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  parameter int LW     = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic [NUM_CH-1:0]           elig,
  input  logic [NUM_CH-1:0][LW-1:0]   chLvl,
  input  logic [LEVELS-1:0][CH_W-1:0] rrPtr,
  output logic                        anyElig,
  output logic [CH_W-1:0]             pickCh,
  output logic [LW-1:0]               pickLvl
);

  always_comb begin
    logic [CH_W-1:0] idx;
    anyElig = 1'b0;
    pickCh  = '0;
    pickLvl = '0;
    idx     = '0;
    for (int lv = 0; lv < LEVELS; lv++) begin
      for (int off = 1; off <= NUM_CH; off++) begin
        idx = CH_W'((int'(rrPtr[lv]) + off) % NUM_CH);
        if (!anyElig && elig[idx] && (chLvl[idx] == LW'(lv))) begin
          anyElig = 1'b1;
          pickCh  = idx;
          pickLvl = LW'(lv);
        end
      end
    end
  end

endmodule

// File: rtl/txch_sched_ctrl.sv
module txch_sched_ctrl
  import txch_sched_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int LEVELS = 4,
  parameter int PRIO_W = 4,
  parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  parameter int LW     = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] chTrig,
  input  logic              cfgWe,
  input  logic [CH_W-1:0]   cfgCh,
  input  logic [PRIO_W-1:0] cfgPrio,
  input  logic              cfgEn,
  input  logic              cfgPause,
  input  logic              cfgTeardown,
  input  pktStrbT           pktS,
  output gateStrbT          gateS,
  output logic              grantValid,
  output logic [CH_W-1:0]   grantCh,
  output logic [NUM_CH-1:0] chEnable,
  output logic [NUM_CH-1:0] tdDone
);

  logic [NUM_CH-1:0][PRIO_W-1:0] prioR;
  logic [NUM_CH-1:0]             enR, pauseR, tdR, tdDoneR;
  logic                          busy;
  logic [CH_W-1:0]               grantChR;
  logic [LW-1:0]                 grantLvl;
  logic [LEVELS-1:0][CH_W-1:0]   rrPtr;

  logic [NUM_CH-1:0]             elig;
  logic [NUM_CH-1:0][LW-1:0]     chLvl;
  logic                          anyElig;
  logic [CH_W-1:0]               pickCh;
  logic [LW-1:0]                 pickLvl;
  logic                          release_;

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      chLvl[i] = (prioR[i] >= PRIO_W'(LEVELS - 1)) ? LW'(LEVELS - 1) : LW'(prioR[i]);
    end
  end

  assign elig = chTrig & enR & ~pauseR & ~tdR;

  txch_prio_pick #(
    .NUM_CH(NUM_CH), .LEVELS(LEVELS), .CH_W(CH_W), .LW(LW)
  ) u_pick (
    .elig   (elig),
    .chLvl  (chLvl),
    .rrPtr  (rrPtr),
    .anyElig(anyElig),
    .pickCh (pickCh),
    .pickLvl(pickLvl)
  );

  assign gateS.pass = busy && enR[grantChR];
  assign release_   = busy && (pktS.eopAcc || !enR[grantChR]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prioR    <= '0;
      enR      <= '0;
      pauseR   <= '0;
      tdR      <= '0;
      tdDoneR  <= '0;
      busy     <= 1'b0;
      grantChR <= '0;
      grantLvl <= '0;
      for (int lv = 0; lv < LEVELS; lv++) rrPtr[lv] <= CH_W'(NUM_CH - 1);
    end else begin
      if (cfgWe) begin
        if (!enR[cfgCh]) prioR[cfgCh] <= cfgPrio;
        enR[cfgCh]    <= cfgEn;
        pauseR[cfgCh] <= cfgPause;
        tdR[cfgCh]    <= cfgTeardown;
        if (cfgEn) tdDoneR[cfgCh] <= 1'b0;
      end
      for (int i = 0; i < NUM_CH; i++) begin
        if (tdR[i] && (!(busy && grantChR == CH_W'(i)) || pktS.eopAcc)) begin
          tdDoneR[i] <= 1'b1;
          enR[i]     <= 1'b0;
          tdR[i]     <= 1'b0;
        end
      end
      if (release_) begin
        busy            <= 1'b0;
        rrPtr[grantLvl] <= grantChR;
      end else if (!busy && anyElig) begin
        busy     <= 1'b1;
        grantChR <= pickCh;
        grantLvl <= pickLvl;
      end
    end
  end

  assign grantValid = gateS.pass;
  assign grantCh    = grantChR;
  assign chEnable   = enR;
  assign tdDone     = tdDoneR;

  // R5
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && enR[grantChR] && !pktS.eopAcc && !cfgWe) |=> (busy && $stable(grantChR)));

  // R8
  dis_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !enR[grantChR]) |=> !busy);

  // R9
  td_clears_en_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((tdDoneR & ~$past(tdDoneR) & enR) == '0));

  // R2
  grant_needs_elig_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> (!busy || $past(anyElig)));

endmodule

// File: rtl/txch_sched_dpath.sv
module txch_sched_dpath
  import txch_sched_pkg::*;
#(
  parameter int DATA_W = 128
) (
  input  gateStrbT          gateS,
  output pktStrbT           pktS,
  input  logic [DATA_W-1:0] srcData,
  input  logic              srcValid,
  input  logic              srcEop,
  output logic              srcReady,
  output logic [DATA_W-1:0] outData,
  output logic              outValid,
  output logic              outEop,
  input  logic              outReady
);

  assign outData     = srcData;
  assign outValid    = srcValid && gateS.pass;
  assign outEop      = srcEop && gateS.pass;
  assign srcReady    = outReady && gateS.pass;
  assign pktS.eopAcc = srcValid && srcEop && outReady && gateS.pass;

endmodule

// File: rtl/txch_sched.sv
module txch_sched
  import txch_sched_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int LEVELS = 4,
  parameter int PRIO_W = 4,
  parameter int DATA_W = 128,
  parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] chTrig,
  input  logic              cfgWe,
  input  logic [CH_W-1:0]   cfgCh,
  input  logic [PRIO_W-1:0] cfgPrio,
  input  logic              cfgEn,
  input  logic              cfgPause,
  input  logic              cfgTeardown,
  input  logic [DATA_W-1:0] srcData,
  input  logic              srcValid,
  input  logic              srcEop,
  output logic              srcReady,
  output logic [DATA_W-1:0] outData,
  output logic              outValid,
  output logic              outEop,
  input  logic              outReady,
  output logic              grantValid,
  output logic [CH_W-1:0]   grantCh,
  output logic [NUM_CH-1:0] chEnable,
  output logic [NUM_CH-1:0] tdDone
);

  gateStrbT gateS;
  pktStrbT  pktS;

  txch_sched_ctrl #(
    .NUM_CH(NUM_CH), .LEVELS(LEVELS), .PRIO_W(PRIO_W), .CH_W(CH_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .chTrig(chTrig),
    .cfgWe(cfgWe), .cfgCh(cfgCh), .cfgPrio(cfgPrio), .cfgEn(cfgEn),
    .cfgPause(cfgPause), .cfgTeardown(cfgTeardown),
    .pktS(pktS), .gateS(gateS),
    .grantValid(grantValid), .grantCh(grantCh),
    .chEnable(chEnable), .tdDone(tdDone)
  );

  txch_sched_dpath #(.DATA_W(DATA_W)) u_dpath (
    .gateS(gateS), .pktS(pktS),
    .srcData(srcData), .srcValid(srcValid), .srcEop(srcEop), .srcReady(srcReady),
    .outData(outData), .outValid(outValid), .outEop(outEop), .outReady(outReady)
  );

endmodule

// File: tb/tb_txch_sched.sv
`timescale 1ns/1ps
module tb_txch_sched;
  localparam int NUM_CH = 4;
  localparam int CH_W   = 2;
  localparam int DATA_W = 128;

  logic              clk = 1'b0;
  logic              rstN;
  logic [NUM_CH-1:0] chTrig;
  logic              cfgWe;
  logic [CH_W-1:0]   cfgCh;
  logic [3:0]        cfgPrio;
  logic              cfgEn, cfgPause, cfgTeardown;
  logic [DATA_W-1:0] srcData;
  logic              srcValid, srcEop, srcReady;
  logic [DATA_W-1:0] outData;
  logic              outValid, outEop, outReady;
  logic              grantValid;
  logic [CH_W-1:0]   grantCh;
  logic [NUM_CH-1:0] chEnable, tdDone;

  int nChecks = 0;
  int nFails  = 0;
  int expQ[$];

  always #2 clk = ~clk;

  txch_sched dut (
    .clk(clk), .rstN(rstN), .chTrig(chTrig),
    .cfgWe(cfgWe), .cfgCh(cfgCh), .cfgPrio(cfgPrio), .cfgEn(cfgEn),
    .cfgPause(cfgPause), .cfgTeardown(cfgTeardown),
    .srcData(srcData), .srcValid(srcValid), .srcEop(srcEop), .srcReady(srcReady),
    .outData(outData), .outValid(outValid), .outEop(outEop), .outReady(outReady),
    .grantValid(grantValid), .grantCh(grantCh), .chEnable(chEnable), .tdDone(tdDone)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
  endtask

  // monitor: pops expected channel at each accepted end-of-packet (R4, R6)
  initial begin
    forever begin
      @(negedge clk);
      #1.5;
      if (outValid && outReady && outEop) begin
        if (expQ.size() == 0) begin
          chk(1'b0, "R5 unexpected eop", int'(grantCh), -1);
        end else begin
          int e;
          e = expQ.pop_front();
          chk(int'(grantCh) == e, "R4 grant order", int'(grantCh), e);
          chk(outData == srcData, "R6 data pass", int'(outData[31:0]), int'(srcData[31:0]));
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  task automatic cfg(input int ch, input int prio, input bit en, input bit pa, input bit td);
    cfgWe = 1'b1; cfgCh = CH_W'(ch); cfgPrio = 4'(prio);
    cfgEn = en; cfgPause = pa; cfgTeardown = td;
    tick();
    cfgWe = 1'b0;
  endtask

  task automatic waitGrant(input int exp, input string req);
    for (int k = 0; k < 20 && !grantValid; k++) tick();
    chk(grantValid && int'(grantCh) == exp, req, grantValid ? int'(grantCh) : -1, exp);
  endtask

  task automatic beat(input bit last);
    srcValid = 1'b1; srcEop = last; outReady = 1'b1;
    srcData = {4{$urandom}};
    tick();
  endtask

  task automatic pkt(input int n, input int exp, input string req);
    expQ.push_back(exp);
    waitGrant(exp, req);
    for (int b = 0; b < n; b++) beat(b == n - 1);
    srcValid = 1'b0; srcEop = 1'b0;
    chk(!grantValid, "R5 release after eop", int'(grantValid), 0);
  endtask

  initial begin
    rstN = 1'b0; chTrig = '0; cfgWe = 1'b0; cfgCh = '0; cfgPrio = '0;
    cfgEn = 1'b0; cfgPause = 1'b0; cfgTeardown = 1'b0;
    srcData = '0; srcValid = 1'b0; srcEop = 1'b0; outReady = 1'b0;
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    // R1 reset state
    chk(!grantValid, "R1 grant idle", int'(grantValid), 0);
    chk(chEnable == '0, "R1 enables", int'(chEnable), 0);
    chk(tdDone == '0, "R1 td flags", int'(tdDone), 0);
    // R2 triggered but disabled: no grant; R6 no pass without grant
    chTrig = 4'b1111; srcValid = 1'b1; outReady = 1'b1;
    tick(); tick();
    chk(!grantValid, "R2 disabled not granted", int'(grantValid), 0);
    chk(!outValid && !srcReady, "R6 gated when idle", int'(outValid), 0);
    srcValid = 1'b0; chTrig = '0;

    cfg(0, 2, 1, 0, 0);
    cfg(1, 2, 1, 0, 0);
    cfg(2, 0, 1, 0, 0);
    cfg(3, 7, 1, 0, 0);
    chTrig = 4'b1111;
    pkt(2, 2, "R3 level 0 first");
    chTrig = 4'b1011;
    pkt(1, 0, "R3 fall through to level 2, R4 start ch0");
    pkt(2, 1, "R4 rotate to ch1");
    pkt(1, 0, "R4 wrap to ch0");

    // R5 hold while sink stalls on eop beat
    expQ.push_back(1);
    waitGrant(1, "R4 ch1 again");
    srcValid = 1'b1; srcEop = 1'b1; outReady = 1'b0;
    tick(); tick();
    chk(grantValid && grantCh == 2'd1 && !srcReady, "R5 hold during stall", int'(grantCh), 1);
    outReady = 1'b1;
    tick();
    srcValid = 1'b0; srcEop = 1'b0;
    chk(!grantValid, "R5 release", int'(grantValid), 0);

    // R7 pause mid-packet on ch0
    expQ.push_back(0);
    waitGrant(0, "R4 ch0 before pause");
    beat(1'b0);
    srcValid = 1'b1; srcEop = 1'b0;
    cfg(0, 2, 1, 1, 0);
    chk(grantValid && grantCh == 2'd0, "R7 packet continues", int'(grantCh), 0);
    beat(1'b1);
    srcValid = 1'b0; srcEop = 1'b0;
    pkt(1, 1, "R7 paused ch0 skipped");
    pkt(1, 1, "R7 paused ch0 still skipped");
    chTrig = '0;
    cfg(0, 2, 1, 0, 0);
    chTrig = 4'b1011;
    pkt(1, 0, "R7 unpaused ch0 served");

    // R10 priority write ignored while enabled
    chTrig = '0;
    cfg(3, 0, 1, 0, 0);
    chTrig = 4'b1010;
    pkt(1, 1, "R10 ignored prio write");
    chTrig = '0;
    cfg(3, 0, 0, 0, 0);
    cfg(3, 0, 1, 0, 0);
    chTrig = 4'b1010;
    pkt(1, 3, "R10 prio applied while disabled, R3");

    // R8 disable mid-packet
    chTrig = 4'b0001;
    waitGrant(0, "R8 ch0 granted");
    beat(1'b0);
    srcValid = 1'b1; srcEop = 1'b0;
    cfg(0, 2, 0, 0, 0);
    chk(!grantValid && !outValid, "R8 immediate stop", int'(outValid), 0);
    srcValid = 1'b0;
    tick(); tick();
    chk(!grantValid && !chEnable[0], "R8 stays stopped", int'(grantValid), 0);

    // R9 teardown on idle channel
    chTrig = '0;
    cfg(2, 0, 1, 0, 1);
    tick();
    chk(tdDone[2] && !chEnable[2], "R9 idle teardown", int'(tdDone[2]), 1);

    // R9 teardown on granted channel, completes at eop
    chTrig = 4'b0010;
    expQ.push_back(1);
    waitGrant(1, "R9 ch1 granted");
    beat(1'b0);
    srcValid = 1'b1; srcEop = 1'b0;
    cfg(1, 2, 1, 0, 1);
    beat(1'b0);
    chk(!tdDone[1] && grantValid, "R9 waits for eop", int'(tdDone[1]), 0);
    beat(1'b1);
    srcValid = 1'b0; srcEop = 1'b0;
    chk(tdDone[1] && !chEnable[1] && !grantValid, "R9 teardown at eop", int'(tdDone[1]), 1);
    chTrig = '0;
    cfg(1, 2, 1, 0, 0);
    chk(!tdDone[1] && chEnable[1], "R9 flag cleared on enable", int'(tdDone[1]), 0);

    tick();
    chk(expQ.size() == 0, "R5 all packets seen", expQ.size(), 0);
    summary();
    $finish;
  end
endmodule